// File: doc/BRIEF.md
# I/O Core Reset and Disable Sequencer

This block owns the low control word of one I/O core and walks it through two fixed procedures. The disable procedure asks the core to reject new traffic, waits for the core to echo the reject request and to finish outstanding work, then holds the core in reset with its clock forced on for a long dwell. It ends with the core parked in reset and reject. The enable procedure first runs the full disable procedure. It then releases the core in three timed steps and clears any latched error status while the core is still held in reset.

A controller pulses `cmd_en` or `cmd_dis` together with a set of core-specific flag bits, which are carried in the upper field of the control word. The sequencer counts dwell times in periods of an external microsecond tick. Each handshake wait is bounded by a cycle counter. When that counter runs out, the sequencer records an error and goes directly to the parking step. `done` marks the end of each accepted command. `core_up` reports whether the current control word leaves the core running.

Top module: `core_rst_seq`

## Requirements
- R1: After reset `ctl_word` is all zero, and `done`, `core_up`, `hs_err`, `clr_high` and `clr_err` are low.
- R2: Control word layout is bit 0 reset, bit 1 reject, bit 2 clock enable, bit 3 force clock, and bits [FLAG_W+3:4] the flags. Disabling a core with clock enable set and reset clear runs four steps: (1) drive reject|clock-enable with a zero flag field; (2) wait for `rej_ack`, then wait for `busy` low; (3) drive force-clock|reset|reject|clock-enable|flags for LONG_US ticks of `us_tick`; (4) drive reset|reject|flags.
- R3: A disable that finds the reset bit set leaves `ctl_word` unchanged. A disable that finds reset and clock enable both clear drives reset|reject|flags at once.
- R4: An enable command first performs the disable procedure of R2/R3 with the same flags. It then drives force-clock|reset|clock-enable|flags and waits SHORT_US ticks. Next it drives force-clock|clock-enable|flags and waits SHORT_US ticks. Finally it drives clock-enable|flags, waits SHORT_US ticks and ends.
- R5: During an enable, once the first SHORT_US wait is over and while the core is still held at force-clock|reset|clock-enable, `clr_high` pulses for one cycle if `serr` is high. In that same cycle `clr_err` pulses if `ib_err` or `tmo_err` is high. A disable command never pulses either strobe.
- R6: If `rej_ack` stays low, or `busy` stays high, for WAIT_LIMIT cycles of a handshake wait, the sequencer sets `hs_err` and drives reset|reject|flags next. `hs_err` stays set until the next command is accepted.
- R7: `done` is high for exactly one cycle at the end of each accepted command.
- R8: A command that arrives while a sequence is running is ignored. If `cmd_en` and `cmd_dis` arrive together while idle, the command is taken as an enable.
- R9: `core_up` is high exactly when, of the clock-enable, reset and reject bits of `ctl_word`, only clock enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_en | input | 1 | Start an enable (reset and release) sequence |
| cmd_dis | input | 1 | Start a disable sequence |
| cmd_flags | input | FLAG_W | Core-specific flag bits for the command |
| rej_ack | input | 1 | Reject bit as read back from the core |
| busy | input | 1 | Core still has outstanding work |
| serr | input | 1 | Latched slave error status |
| ib_err | input | 1 | Latched in-band error status |
| tmo_err | input | 1 | Latched timeout status |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| ctl_word | output | FLAG_W+4 | Control word driven to the core |
| clr_high | output | 1 | Strobe: clear the core's high status word |
| clr_err | output | 1 | Strobe: clear in-band error and timeout status |
| done | output | 1 | Sequence finished (one cycle) |
| core_up | output | 1 | Core is running per the control word |
| hs_err | output | 1 | A handshake wait timed out |

## Verification
The bound checker enforces several rules on every cycle:
- The reset-with-forced-clock word is written only after `busy` has been seen low.
- The core leaves the reject-request word only after an echo or a timeout.
- The long hold ends only after its tick count has run out.
- The error strobes fire only while the core is held at force-clock|reset|clock-enable.
- `done` never lasts two cycles.
- `hs_err` rises only from an expired wait.
- The latched flags stay put while a sequence runs.

Only the bench scenarios show the full ordering of control words for each starting state of the core, and the exact tick counts of each dwell. They also show which strobes fire for a given status, that a late command is ignored, and that `core_up` is right after each sequence.

// File: rtl/core_rst_seq_pkg.sv
package core_rst_seq_pkg;
  // bit positions in the low nibble of the control word
  localparam int B_RST = 0;
  localparam int B_REJ = 1;
  localparam int B_CLK = 2;
  localparam int B_FGC = 3;
  localparam int LOW_W = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_WREJ, S_WBSY, S_HOLD, S_PARK,
    S_ERST, S_EW1, S_ECLR, S_EW2, S_EW3, S_DONE
  } seq_state_t;

  // running means: of clock, reset and reject only clock is set
  function automatic logic core_is_up(input logic [LOW_W-1:0] low);
    return low[B_CLK] && !low[B_RST] && !low[B_REJ];
  endfunction
endpackage

// File: rtl/seq_dwell_timer.sv
module seq_dwell_timer #(
  parameter int MAX_US = 10,
  localparam int US_W = $clog2(MAX_US + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [US_W-1:0] len_us,
  input  logic            tick,
  output logic            elapsed
);
  logic [US_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remain_q <= '0;
    else if (start) remain_q <= len_us;
    else if (tick && remain_q != '0) remain_q <= remain_q - 1'b1;
  end

  assign elapsed = (remain_q == '0);
endmodule

// File: rtl/seq_wait_guard.sv
module seq_wait_guard #(
  parameter int LIMIT = 32,
  localparam int G_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  logic [G_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (!run) cnt_q <= '0;
    else if (!expired) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == G_W'(LIMIT));
endmodule

// File: rtl/core_rst_seq.sv
module core_rst_seq
  import core_rst_seq_pkg::*;
#(
  parameter int FLAG_W     = 8,
  parameter int SHORT_US   = 1,
  parameter int LONG_US    = 10,
  parameter int WAIT_LIMIT = 32,
  localparam int CTRL_W    = FLAG_W + LOW_W,
  localparam int US_W      = $clog2(LONG_US + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_en,
  input  logic              cmd_dis,
  input  logic [FLAG_W-1:0] cmd_flags,
  input  logic              rej_ack,
  input  logic              busy,
  input  logic              serr,
  input  logic              ib_err,
  input  logic              tmo_err,
  input  logic              us_tick,
  output logic [CTRL_W-1:0] ctl_word,
  output logic              clr_high,
  output logic              clr_err,
  output logic              done,
  output logic              core_up,
  output logic              hs_err
);
  seq_state_t        st_q;
  logic [CTRL_W-1:0] ctl_q;
  logic [FLAG_W-1:0] flags_q;
  logic              mode_en_q;
  logic              hs_err_q;

  // named internal events
  logic              seq_active;
  logic              cmd_take;
  logic              dwell_start;
  logic [US_W-1:0]   dwell_len;
  logic              dwell_elapsed;
  logic              guard_run;
  logic              guard_expired;

  function automatic logic [CTRL_W-1:0] mk_ctl(input logic fgc, input logic rst,
                                               input logic rej, input logic clk_en,
                                               input logic [FLAG_W-1:0] f);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[B_FGC] = fgc;
    w[B_RST] = rst;
    w[B_REJ] = rej;
    w[B_CLK] = clk_en;
    w[CTRL_W-1:LOW_W] = f;
    return w;
  endfunction

  assign seq_active = (st_q != S_IDLE);
  assign cmd_take   = !seq_active && (cmd_en || cmd_dis);
  assign guard_run  = (st_q == S_WREJ && !rej_ack) || (st_q == S_WBSY && busy);

  always_comb begin
    dwell_start = 1'b0;
    dwell_len   = US_W'(SHORT_US);
    case (st_q)
      S_WBSY: if (!busy) begin
        dwell_start = 1'b1;
        dwell_len   = US_W'(LONG_US);
      end
      S_ERST, S_ECLR: dwell_start = 1'b1;
      S_EW2: dwell_start = dwell_elapsed;
      default: ;
    endcase
  end

  seq_dwell_timer #(.MAX_US(LONG_US)) u_dwell (
    .clk(clk), .rst_n(rst_n), .start(dwell_start), .len_us(dwell_len),
    .tick(us_tick), .elapsed(dwell_elapsed)
  );

  seq_wait_guard #(.LIMIT(WAIT_LIMIT)) u_guard (
    .clk(clk), .rst_n(rst_n), .run(guard_run), .expired(guard_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      ctl_q     <= '0;
      flags_q   <= '0;
      mode_en_q <= 1'b0;
      hs_err_q  <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (cmd_take) begin
          flags_q   <= cmd_flags;
          mode_en_q <= cmd_en;
          hs_err_q  <= 1'b0;
          st_q      <= S_CHK;
        end
        S_CHK: begin
          if (ctl_q[B_RST]) st_q <= mode_en_q ? S_ERST : S_DONE;
          else if (!ctl_q[B_CLK]) st_q <= S_PARK;
          else begin
            ctl_q <= mk_ctl(1'b0, 1'b0, 1'b1, 1'b1, '0);
            st_q  <= S_WREJ;
          end
        end
        S_WREJ: begin
          if (rej_ack) st_q <= S_WBSY;
          else if (guard_expired) begin
            hs_err_q <= 1'b1;
            st_q     <= S_PARK;
          end
        end
        S_WBSY: begin
          if (!busy) begin
            ctl_q <= mk_ctl(1'b1, 1'b1, 1'b1, 1'b1, flags_q);
            st_q  <= S_HOLD;
          end else if (guard_expired) begin
            hs_err_q <= 1'b1;
            st_q     <= S_PARK;
          end
        end
        S_HOLD: if (dwell_elapsed) st_q <= S_PARK;
        S_PARK: begin
          ctl_q <= mk_ctl(1'b0, 1'b1, 1'b1, 1'b0, flags_q);
          st_q  <= mode_en_q ? S_ERST : S_DONE;
        end
        S_ERST: begin
          ctl_q <= mk_ctl(1'b1, 1'b1, 1'b0, 1'b1, flags_q);
          st_q  <= S_EW1;
        end
        S_EW1: if (dwell_elapsed) st_q <= S_ECLR;
        S_ECLR: begin
          ctl_q <= mk_ctl(1'b1, 1'b0, 1'b0, 1'b1, flags_q);
          st_q  <= S_EW2;
        end
        S_EW2: if (dwell_elapsed) begin
          ctl_q <= mk_ctl(1'b0, 1'b0, 1'b0, 1'b1, flags_q);
          st_q  <= S_EW3;
        end
        S_EW3: if (dwell_elapsed) st_q <= S_DONE;
        S_DONE: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign ctl_word = ctl_q;
  assign done     = (st_q == S_DONE);
  assign clr_high = (st_q == S_ECLR) && serr;
  assign clr_err  = (st_q == S_ECLR) && (ib_err || tmo_err);
  assign core_up  = core_is_up(ctl_q[LOW_W-1:0]);
  assign hs_err   = hs_err_q;
endmodule

// File: rtl/core_rst_seq_chk.sv
module core_rst_seq_chk #(
  parameter int FLAG_W = 8,
  localparam int CTRL_W = FLAG_W + 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CTRL_W-1:0] ctl_word,
  input logic              done,
  input logic              clr_high,
  input logic              clr_err,
  input logic              rej_ack,
  input logic              busy,
  input logic              hs_err,
  input logic              guard_expired,
  input logic              dwell_elapsed,
  input logic              seq_active,
  input logic [FLAG_W-1:0] lat_flags
);
  // reset-with-forced-clock word only after busy was seen low
  assert_busy_before_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl_word[3:0]) == 4'b0110 && ctl_word[3:0] == 4'b1111) |-> !$past(busy));

  // leaving the reject-request word needs an echo or an expired wait
  assert_reject_echo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl_word[3:0]) == 4'b0110 && ctl_word[3:0] != 4'b0110)
      |-> ($past(rej_ack) || $past(guard_expired)));

  // long hold ends only after the dwell ran out
  assert_hold_dwell_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl_word[3:0]) == 4'b1111 && ctl_word[3:0] != 4'b1111) |-> $past(dwell_elapsed, 2));

  // error strobes only while the core is held at force-clock|reset|clock-enable
  assert_clear_in_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_high || clr_err) |-> ctl_word[3:0] == 4'b1101);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_from_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_err) |-> $past(guard_expired));

  assert_flags_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_active |=> $stable(lat_flags));
endmodule

bind core_rst_seq core_rst_seq_chk #(.FLAG_W(FLAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_word(ctl_word), .done(done),
  .clr_high(clr_high), .clr_err(clr_err), .rej_ack(rej_ack), .busy(busy),
  .hs_err(hs_err), .guard_expired(guard_expired), .dwell_elapsed(dwell_elapsed),
  .seq_active(seq_active), .lat_flags(flags_q)
);

// File: tb/sim_core_rst_seq.sv
module sim_core_rst_seq;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 8;
  localparam int CW = FW + 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_en = 0, cmd_dis = 0;
  logic [FW-1:0] cmd_flags = '0;
  logic rej_ack = 0, busy = 0, serr = 0, ib_err = 0, tmo_err = 0, us_tick = 0;
  logic [CW-1:0] ctl_word;
  logic clr_high, clr_err, done, core_up, hs_err;

  core_rst_seq #(.FLAG_W(FW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_flags(cmd_flags),
    .rej_ack(rej_ack), .busy(busy), .serr(serr), .ib_err(ib_err), .tmo_err(tmo_err),
    .us_tick(us_tick), .ctl_word(ctl_word), .clr_high(clr_high), .clr_err(clr_err),
    .done(done), .core_up(core_up), .hs_err(hs_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [CW-1:0] mdl_ctl = '0;

  // responder settings
  int rlat = 0, blat = 0, rcnt = 0, bcnt = 0, tick_ph = 0;
  bit busy_on = 0;

  // observation
  logic [CW-1:0] obs_ctl[$];
  int obs_tk[$];
  logic [CW-1:0] last_ctl = '0;
  int tick_acc = 0, done_cnt = 0, done_tk = 0, ch_cnt = 0, ce_cnt = 0;

  function automatic logic [CW-1:0] mk(input bit fgc, input bit rst, input bit rej,
                                       input bit ck, input logic [FW-1:0] f);
    return {f, fgc, ck, rej, rst};
  endfunction

  function automatic bit up_of(input logic [CW-1:0] w);
    return w[2] && !w[0] && !w[1];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // environment: tick generator and core model
  initial forever begin
    @(posedge clk); #1;
    tick_ph = (tick_ph + 1) % 4;
    us_tick = (tick_ph == 0);
    if (ctl_word[1] && rlat >= 0) begin
      if (rcnt >= rlat) rej_ack = 1; else rcnt++;
    end else begin
      rej_ack = 0; rcnt = 0;
    end
    if (rej_ack) bcnt++; else bcnt = 0;
    if (!busy_on) busy = 0;
    else if (rej_ack && blat >= 0 && bcnt > blat) busy = 0;
    else busy = 1;
  end

  // observer at the falling edge
  initial forever begin
    @(negedge clk);
    if (ctl_word !== last_ctl) begin
      obs_ctl.push_back(ctl_word);
      obs_tk.push_back(tick_acc);
      tick_acc = 0;
      last_ctl = ctl_word;
    end
    if (done) begin done_cnt++; done_tk = tick_acc; end
    if (clr_high) ch_cnt++;
    if (clr_err) ce_cnt++;
    if (us_tick) tick_acc++;
  end

  task automatic run_cmd(input bit en, input logic [FW-1:0] f, input int rl, input int bl,
                         input bit se, input bit ie, input bit te, input bit poke, input bit both);
    logic [CW-1:0] e_ctl[$];
    int e_tk[$];
    logic [CW-1:0] cur;
    bit herr;
    string rq;
    int w;
    cur = mdl_ctl;
    herr = 0;
    // R3 / R2 / R6 expected disable part
    if (cur[0]) begin
    end else if (!cur[2]) begin
      e_ctl.push_back(mk(0, 1, 1, 0, f)); e_tk.push_back(-1);
    end else begin
      e_ctl.push_back(mk(0, 0, 1, 1, '0)); e_tk.push_back(-1);
      if (rl < 0 || bl < 0) begin
        herr = 1;
        e_ctl.push_back(mk(0, 1, 1, 0, f)); e_tk.push_back(-1);
      end else begin
        e_ctl.push_back(mk(1, 1, 1, 1, f)); e_tk.push_back(-1);
        e_ctl.push_back(mk(0, 1, 1, 0, f)); e_tk.push_back(10);
      end
    end
    // R4 enable part
    if (en || both) begin
      e_ctl.push_back(mk(1, 1, 0, 1, f)); e_tk.push_back(-1);
      e_ctl.push_back(mk(1, 0, 0, 1, f)); e_tk.push_back(1);
      e_ctl.push_back(mk(0, 0, 0, 1, f)); e_tk.push_back(1);
    end
    rq = herr ? "R6" : (en || both) ? "R4" : (cur[2] && !cur[0]) ? "R2" : "R3";
    if (poke || both) rq = "R8";

    @(posedge clk); #1;
    obs_ctl.delete(); obs_tk.delete();
    done_cnt = 0; ch_cnt = 0; ce_cnt = 0;
    rlat = rl; blat = bl; busy_on = 1;
    serr = se; ib_err = ie; tmo_err = te;
    cmd_flags = f; cmd_en = en || both; cmd_dis = !en || both;
    @(posedge clk); #1;
    cmd_en = 0; cmd_dis = 0;
    if (poke) begin
      repeat (2) @(posedge clk);
      #1; cmd_flags = ~f; cmd_dis = 1; cmd_en = 1;
      @(posedge clk); #1; cmd_dis = 0; cmd_en = 0;
    end
    w = 0;
    while (done_cnt == 0 && w < 3000) begin @(negedge clk); w++; end
    repeat (4) @(negedge clk);
    busy_on = 0;

    chk(obs_ctl.size() == e_ctl.size(), rq, "word count", obs_ctl.size(), e_ctl.size());
    for (int i = 0; i < e_ctl.size() && i < obs_ctl.size(); i++) begin
      chk(obs_ctl[i] == e_ctl[i], rq, "ctl word", int'(obs_ctl[i]), int'(e_ctl[i]));
      if (e_tk[i] >= 0) chk(obs_tk[i] == e_tk[i], rq, "dwell ticks", obs_tk[i], e_tk[i]);
    end
    chk(done_cnt == 1, "R7", "done cycles", done_cnt, 1);
    if (en || both) chk(done_tk == 1, "R4", "final dwell ticks", done_tk, 1);
    chk(ch_cnt == ((en || both) && se ? 1 : 0), "R5", "clr_high pulses", ch_cnt, (en || both) && se);
    chk(ce_cnt == ((en || both) && (ie || te) ? 1 : 0), "R5", "clr_err pulses", ce_cnt,
        (en || both) && (ie || te));
    chk(hs_err == herr, "R6", "hs_err", hs_err, herr);
    if (e_ctl.size() > 0) mdl_ctl = e_ctl[e_ctl.size()-1];
    chk(core_up == up_of(mdl_ctl), "R9", "core_up", core_up, up_of(mdl_ctl));
    chk(ctl_word == mdl_ctl, rq, "final word", int'(ctl_word), int'(mdl_ctl));
  endtask

  initial begin
    int sd;
    sd = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(ctl_word == '0, "R1", "ctl after reset", int'(ctl_word), 0);
    chk(!done && !core_up && !hs_err && !clr_high && !clr_err, "R1", "flags after reset",
        {done, core_up, hs_err, clr_high, clr_err}, 0);

    run_cmd(0, 8'h3C, 1, 1, 1, 1, 1, 0, 0); // R3 clock clear -> park at once
    run_cmd(0, 8'h11, 1, 1, 0, 0, 0, 0, 0); // R3 reset set -> no change
    run_cmd(1, 8'hA5, 1, 1, 1, 0, 0, 0, 0); // R4 from reset, R5 serr only
    run_cmd(0, 8'h5A, 2, 3, 0, 1, 0, 0, 0); // R2 full handshake
    run_cmd(1, 8'h0F, 0, 0, 0, 0, 1, 1, 0); // R8 late command ignored
    run_cmd(1, 8'hC3, -1, 0, 0, 0, 0, 0, 0); // R6 reject never echoed
    run_cmd(0, 8'h81, 1, 1, 0, 0, 0, 0, 0);
    run_cmd(1, 8'h42, 1, 1, 0, 0, 0, 0, 1); // R8 both at once -> enable
    run_cmd(0, 8'h24, 0, -1, 1, 1, 1, 0, 0); // R6 busy stuck

    for (int n = 0; n < 40; n++) begin
      int rl, bl;
      rl = ($urandom % 8 == 0) ? -1 : int'($urandom % 7);
      bl = ($urandom % 8 == 0) ? -1 : int'($urandom % 9);
      run_cmd($urandom % 2, FW'($urandom), rl, bl, $urandom % 2, $urandom % 2,
              $urandom % 2, 0, 0);
    end

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end
endmodule